// File: doc/BRIEF.md
# CAN Receive Acceptance Filter and Double Receive Buffer

This block sits between a CAN frame receiver and the host processor. The receiver hands over each frame as a byte stream: two descriptor bytes first, then up to eight data bytes. The first descriptor byte carries identifier bits 10 down to 3. On that first byte the block compares those eight bits with a programmable code/mask pair and decides whether the frame is wanted. A wanted frame is written byte by byte into a free receive buffer. The buffer becomes visible to the host only when the receiver signals that the frame ended correctly. Frames that the node itself transmits arrive on the same stream and are handled in the same way. Whether the node will win arbitration is unknown at the start of a frame, so a wanted frame that finds no free buffer raises overrun at once.

Two 10-byte buffers are filled in turn. The host always sees the oldest full buffer through a byte index. A release strobe hands that buffer back. A register port holds the configuration-mode bit, the receive-interrupt enable, the code and mask values, a read-to-clear interrupt register and a status register.

The frame stream uses valid/ready. A byte transfers on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is low only while the configuration-mode bit is set, and then no byte is taken. In normal operation `s_ready` stays high, because a CAN receiver cannot be stalled. The end-OK and abort strobes are plain single-cycle pulses, outside the handshake.

Top module: `can_rx_filter`

## Requirements
- R1: A frame is wanted when, for each bit b in 0..7 of its first byte (identifier bit 10 at bit 7, down to identifier bit 3 at bit 0), the bit equals code bit b or mask bit b is 1.
- R2: Mask bit 1 makes a position don't-care and mask bit 0 makes it relevant. A mask of 0xFF therefore accepts every identifier.
- R3: Register map: address 0 is control (bit 0 configuration mode, reset value 1; bit 1 receive-interrupt enable, reset value 0), address 1 is code, address 2 is mask (both reset to 0x00). Writes to addresses 1 and 2 take effect only while bit 0 of control is 1. Reads of those addresses return the value in that mode and 0xFF otherwise.
- R4: A wanted frame that finds a free buffer is stored in arrival order at indices 0..9 (first descriptor byte at index 0). Bytes after the tenth are discarded.
- R5: A wanted frame that finds no free buffer sets the data-overrun flag and changes no stored buffer.
- R6: The buffer-full flag (`rb_full`, also status bit 0) rises only on the cycle after an end-OK strobe and stays low while a frame is still arriving.
- R7: On correct completion, the receive interrupt (`rx_irq`, interrupt register bit 0 at address 3) is set only if the enable bit is 1. A read of address 3 clears it, and a new completion in the same cycle wins.
- R8: An abort strobe during a frame returns the partly filled buffer to empty and raises no flag or interrupt.
- R9: Buffers are filled alternately and read oldest first. A release strobe empties the oldest full buffer, and `rb_full` stays high while another buffer is full. A completion and a release in the same cycle both take effect.
- R10: Data overrun (status bit 1) stays set until a clear-overrun strobe. A new overrun in the same cycle as the clear wins.
- R11: While the configuration-mode bit is 1, `s_ready` is low and no frame is received.
- R12: A frame that fails the filter changes no buffer, flag or interrupt, even when both buffers are full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the interrupt register on address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| s_valid | input | 1 | Frame byte valid |
| s_ready | output | 1 | Frame byte accepted |
| s_data | input | 8 | Frame byte |
| s_first | input | 1 | Marks the first descriptor byte of a frame |
| fr_end_ok | input | 1 | Frame finished correctly (pulse) |
| fr_abort | input | 1 | Frame abandoned (pulse) |
| rb_full | output | 1 | At least one buffer holds a complete frame |
| rb_index | input | 4 | Byte index into the oldest full buffer |
| rb_data | output | 8 | Byte at `rb_index` of the oldest full buffer |
| rb_release | input | 1 | Empty the oldest full buffer (pulse) |
| clr_overrun | input | 1 | Clear the data-overrun flag (pulse) |
| data_overrun | output | 1 | Data-overrun flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the end-OK strobe of a frame going into one buffer and a host release of the other buffer. The bench raises both strobes on one edge. It then expects `rb_full` to stay high and the byte at index 0 to be the identifier of the newly completed frame. The second pair is a clear-overrun strobe and a wanted frame start that finds both buffers full. The bench drives both together and expects overrun to remain set, with the oldest buffer unchanged. Acceptance is swept over all 256 identifiers for several code/mask pairs, and each expected outcome is computed arithmetically.

// File: rtl/canrx_pkg.sv
package canrx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    BUF_EMPTY = 2'd0,
    BUF_FILL  = 2'd1,
    BUF_FULL  = 2'd2
  } buf_state_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_IRQ  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
endpackage

// File: rtl/canrx_accept.sv
module canrx_accept #(
  parameter int W = 8
) (
  input  logic [W-1:0] id_hi,
  input  logic [W-1:0] code,
  input  logic [W-1:0] mask,
  output logic         hit
);
  logic [W-1:0] pos_ok;

  // each position passes when it matches or is marked don't-care
  for (genvar b = 0; b < W; b++) begin : g_pos
    assign pos_ok[b] = mask[b] | ~(id_hi[b] ^ code[b]);
  end

  assign hit = &pos_ok;
endmodule

// File: rtl/canrx_cfg.sv
module canrx_cfg
  import canrx_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          cfg_mode,
  output logic [DW-1:0] code,
  output logic [DW-1:0] mask,
  input  logic          frame_done,
  input  logic          ovr_evt,
  input  logic          clr_ovr,
  input  logic          any_full,
  output logic          rx_int,
  output logic          ovr
);
  logic rie;
  logic irq_read;

  assign irq_read = reg_rd && (reg_addr == A_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode <= 1'b1;
      rie      <= 1'b0;
      code     <= '0;
      mask     <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) begin
        cfg_mode <= reg_wdata[0];
        rie      <= reg_wdata[1];
      end
      if (cfg_mode && reg_addr == A_CODE) code <= reg_wdata;
      if (cfg_mode && reg_addr == A_MASK) mask <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_int <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (frame_done && rie) rx_int <= 1'b1;
      else if (irq_read)     rx_int <= 1'b0;
      if (ovr_evt)           ovr <= 1'b1;
      else if (clr_ovr)      ovr <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata = DW'({rie, cfg_mode});
      A_CODE: reg_rdata = cfg_mode ? code : '1;
      A_MASK: reg_rdata = cfg_mode ? mask : '1;
      A_IRQ:  reg_rdata = DW'(rx_int);
      A_STAT: reg_rdata = DW'({ovr, any_full});
      default: reg_rdata = '0;
    endcase
  end

  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> ($stable(code) && $stable(mask)));

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_ovr) |=> ovr);

  p_int_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_int) |-> $past(rie));
endmodule

// File: rtl/canrx_rxbuf.sv
module canrx_rxbuf
  import canrx_pkg::*;
#(
  parameter int NBUF  = 2,
  parameter int DEPTH = 10,
  parameter int DW    = BYTE_W,
  localparam int PW   = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_take,
  input  logic          in_first,
  input  logic [DW-1:0] in_data,
  input  logic          accept,
  input  logic          end_ok,
  input  logic          abort,
  input  logic          release_buf,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          any_full,
  output logic          frame_done,
  output logic          ovr_evt
);
  buf_state_e        st  [NBUF];
  logic [DW-1:0]     mem [NBUF][DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;
  logic [NBUF-1:0]   fill_vec, full_vec;

  logic start_take, cur_fill, free_slot, store_first, store_next, drop, rel;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(NBUF - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < NBUF; i++) begin : g_flags
    assign fill_vec[i] = (st[i] == BUF_FILL);
    assign full_vec[i] = (st[i] == BUF_FULL);
  end

  assign start_take  = in_take & in_first;
  assign cur_fill    = (st[wr_ptr] == BUF_FILL);
  assign free_slot   = (st[wr_ptr] != BUF_FULL);
  assign store_first = start_take & accept & free_slot;
  assign ovr_evt     = start_take & accept & ~free_slot;
  assign store_next  = in_take & ~in_first & cur_fill & (cnt < CW'(DEPTH));
  assign drop        = abort & cur_fill & ~start_take;
  assign frame_done  = end_ok & cur_fill & ~start_take & ~abort;
  assign rel         = release_buf & (st[rd_ptr] == BUF_FULL);
  assign any_full    = |full_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) st[i] <= BUF_EMPTY;
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (start_take) begin
        if (store_first)   st[wr_ptr] <= BUF_FILL;
        else if (cur_fill) st[wr_ptr] <= BUF_EMPTY;
      end else if (drop) begin
        st[wr_ptr] <= BUF_EMPTY;
      end else if (frame_done) begin
        st[wr_ptr] <= BUF_FULL;
        wr_ptr     <= nxt(wr_ptr);
      end
      if (rel) begin
        st[rd_ptr] <= BUF_EMPTY;
        rd_ptr     <= nxt(rd_ptr);
      end
      if (store_first)     cnt <= CW'(1);
      else if (store_next) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (store_first)     mem[wr_ptr][0] <= in_data;
    else if (store_next) mem[wr_ptr][IW'(cnt)] <= in_data;
  end

  assign rd_data = (int'(rd_idx) < DEPTH) ? mem[rd_ptr][rd_idx] : '0;

  p_onehot_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_vec));

  p_full_needs_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_full) |-> $past(end_ok));

  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && cur_fill && !start_take) |=> (fill_vec == '0));

  p_release_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && $countones(full_vec) == 1 && !frame_done) |=> !any_full);
endmodule

// File: rtl/can_rx_filter.sv
module can_rx_filter
  import canrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_first,
  input  logic        fr_end_ok,
  input  logic        fr_abort,
  output logic        rb_full,
  input  logic [3:0]  rb_index,
  output logic [7:0]  rb_data,
  input  logic        rb_release,
  input  logic        clr_overrun,
  output logic        data_overrun,
  output logic        rx_irq
);
  localparam int NBUF  = 2;
  localparam int DEPTH = 10;

  logic       cfg_mode, hit, in_take, frame_done, ovr_evt;
  logic [7:0] code, mask;

  assign s_ready = ~cfg_mode;
  assign in_take = s_valid & s_ready;

  canrx_cfg #(.DW(BYTE_W), .AW(ADDR_W)) u_cfg (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .cfg_mode, .code, .mask,
    .frame_done, .ovr_evt, .clr_ovr(clr_overrun), .any_full(rb_full),
    .rx_int(rx_irq), .ovr(data_overrun)
  );

  canrx_accept #(.W(BYTE_W)) u_accept (
    .id_hi(s_data), .code, .mask, .hit
  );

  canrx_rxbuf #(.NBUF(NBUF), .DEPTH(DEPTH), .DW(BYTE_W)) u_buf (
    .clk, .rst_n, .in_take, .in_first(s_first), .in_data(s_data),
    .accept(hit), .end_ok(fr_end_ok), .abort(fr_abort),
    .release_buf(rb_release), .rd_idx(rb_index), .rd_data(rb_data),
    .any_full(rb_full), .frame_done, .ovr_evt
  );

  p_no_take_in_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |=> $stable(rb_full) || $past(rb_release) || $past(fr_end_ok));
endmodule

// File: tb/tb_can_rx_filter.sv
`timescale 1ns/1ps
module tb_can_rx_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, s_data = 0, rb_data;
  logic s_valid = 0, s_ready, s_first = 0, fr_end_ok = 0, fr_abort = 0;
  logic rb_full, rb_release = 0, clr_overrun = 0, data_overrun, rx_irq;
  logic [3:0] rb_index = 0;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  can_rx_filter dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic setcfg(input logic [7:0] c, input logic [7:0] m, input logic [7:0] ctl);
    wr(3'd0, 8'h01); wr(3'd1, c); wr(3'd2, m); wr(3'd0, ctl);
  endtask

  task automatic push(input logic [7:0] d, input logic first);
    @(negedge clk); s_valid = 1; s_first = first; s_data = d;
  endtask

  task automatic finish_frame(input bit ok);
    @(negedge clk); s_valid = 0; s_first = 0;
    if (ok) fr_end_ok = 1; else fr_abort = 1;
    @(negedge clk); fr_end_ok = 0; fr_abort = 0;
  endtask

  function automatic logic [7:0] dat(input logic [7:0] id, input int k);
    return id + 8'(8'h11 * (k + 1));
  endfunction

  task automatic send(input logic [7:0] id, input int nd, input bit ok);
    push(id, 1'b1); push(8'(nd), 1'b0);
    for (int k = 0; k < nd; k++) push(dat(id, k), 1'b0);
    finish_frame(ok);
  endtask

  task automatic rel();
    @(negedge clk); rb_release = 1; @(negedge clk); rb_release = 0;
  endtask

  task automatic byte_at(input int i, output logic [7:0] d);
    rb_index = 4'(i); #1 d = rb_data;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] cs [5] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81};
    logic [7:0] ms [5] = '{8'h0F, 8'h00, 8'h00, 8'hFF, 8'h7E};

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    rd(3'd0, d); chk("R3 ctrl reset", d, 8'h01);
    rd(3'd1, d); chk("R3 code reset", d, 8'h00);
    chk("R11 ready low in cfg", s_ready, 0);
    chk("R6 full reset", rb_full, 0);
    chk("R10 ovr reset", data_overrun, 0);
    chk("R7 irq reset", rx_irq, 0);

    // R11: no reception in configuration mode
    send(8'h00, 0, 1);
    chk("R11 frame ignored", rb_full, 0);

    // R3: locking of code/mask
    setcfg(8'hA5, 8'h0F, 8'h02);
    chk("R11 ready high", s_ready, 1);
    wr(3'd1, 8'h00); wr(3'd2, 8'hFF);
    rd(3'd1, d); chk("R3 code hidden", d, 8'hFF);
    wr(3'd0, 8'h01);
    rd(3'd1, d); chk("R3 code kept", d, 8'hA5);
    rd(3'd2, d); chk("R3 mask kept", d, 8'h0F);

    // R1 R2 R12: sweep all identifiers for several code/mask pairs
    for (int p = 0; p < 5; p++) begin
      setcfg(cs[p], ms[p], 8'h02);
      for (int id = 0; id < 256; id++) begin
        int exp;
        exp = ((((id ^ int'(cs[p])) & ~int'(ms[p])) & 8'hFF) == 0) ? 1 : 0;
        send(8'(id), 0, 1);
        chk("R1 R2 accept", rb_full, exp);
        if (exp == 1) begin
          byte_at(0, d); chk("R4 id stored", d, id);
          chk("R7 irq set", rx_irq, 1);
          rd(3'd3, d); chk("R7 irq reg", d, 1);
          chk("R7 irq cleared", rx_irq, 0);
          rel();
        end else begin
          chk("R12 no irq", rx_irq, 0);
        end
      end
    end

    // R6 and R4: order, truncation, no flag mid-frame
    setcfg(8'h00, 8'hFF, 8'h02);
    push(8'h12, 1'b1); push(8'h08, 1'b0);
    for (int k = 0; k < 9; k++) push(dat(8'h12, k), 1'b0);
    @(negedge clk); s_valid = 0;
    chk("R6 not full mid-frame", rb_full, 0);
    chk("R6 no irq mid-frame", rx_irq, 0);
    finish_frame(1);
    chk("R6 full after end", rb_full, 1);
    byte_at(1, d); chk("R4 descriptor", d, 8'h08);
    for (int k = 0; k < 8; k++) begin
      byte_at(k + 2, d); chk("R4 data order", d, dat(8'h12, k));
    end
    rd(3'd3, d);

    // R9: alternate fill, oldest first
    send(8'h34, 0, 1);
    byte_at(0, d); chk("R9 oldest first", d, 8'h12);
    rel();
    chk("R9 still full", rb_full, 1);
    byte_at(0, d); chk("R9 next oldest", d, 8'h34);
    rel();
    chk("R9 all empty", rb_full, 0);

    // concurrency: completion and release in one cycle
    send(8'h41, 0, 1);
    push(8'h42, 1'b1); push(8'h00, 1'b0);
    @(negedge clk); s_valid = 0; s_first = 0; fr_end_ok = 1; rb_release = 1;
    @(negedge clk); fr_end_ok = 0; rb_release = 0;
    chk("R9 concurrent full", rb_full, 1);
    byte_at(0, d); chk("R9 concurrent oldest", d, 8'h42);
    rel();
    chk("R9 concurrent empty", rb_full, 0);
    rd(3'd3, d);

    // R5 R10: overrun, set wins over clear
    send(8'h51, 0, 1); send(8'h52, 0, 1);
    @(negedge clk); s_valid = 1; s_first = 1; s_data = 8'h53; clr_overrun = 1;
    @(negedge clk); s_valid = 0; s_first = 0; clr_overrun = 0; fr_end_ok = 1;
    @(negedge clk); fr_end_ok = 0;
    chk("R10 set wins", data_overrun, 1);
    byte_at(0, d); chk("R5 oldest unchanged", d, 8'h51);
    rd(3'd4, d); chk("R10 status", d, 8'h03);
    repeat (4) @(negedge clk);
    chk("R10 sticky", data_overrun, 1);
    @(negedge clk); clr_overrun = 1; @(negedge clk); clr_overrun = 0;
    chk("R10 cleared", data_overrun, 0);

    // R12: rejected frame with both buffers full
    setcfg(8'h55, 8'h00, 8'h02);
    send(8'h54, 0, 1);
    chk("R12 no overrun", data_overrun, 0);
    byte_at(0, d); chk("R12 buffer kept", d, 8'h51);
    rel(); rel();
    chk("R5 released", rb_full, 0);
    rd(3'd3, d);

    // R8: abort
    setcfg(8'h00, 8'hFF, 8'h02);
    send(8'h61, 3, 0);
    chk("R8 abort not full", rb_full, 0);
    chk("R8 abort no irq", rx_irq, 0);
    send(8'h62, 0, 1);
    byte_at(0, d); chk("R8 next frame", d, 8'h62);
    rel(); rd(3'd3, d);

    // R7: interrupt disabled
    wr(3'd0, 8'h00);
    send(8'h70, 0, 1);
    chk("R7 full no enable", rb_full, 1);
    chk("R7 no irq", rx_irq, 0);
    rd(3'd3, d); chk("R7 irq reg zero", d, 0);
    rel();

    summary();
    $finish;
  end
endmodule